// File: doc/BRIEF.md
# Floating-Point Load Result Formatter

This block sits at the end of a floating-point load path. It takes the raw data that memory returned for the load, together with a two-bit format select. From these it builds the 64-bit value that the load writes into a floating-point register.

There are four formats:
- A single-precision value is widened exactly to double precision.
- A double-precision value passes through unchanged.
- A 32-bit integer word is placed in the low half of the result, with either sign fill or zero fill above it.

The result is registered once and qualified by a valid flag. Bits are numbered so that bit 0 is the most significant bit of the 64-bit result. In SystemVerilog terms, register bits 0:31 are `out_data_o[63:32]` and bits 32:63 are `out_data_o[31:0]`. For 32-bit accesses the word sits in `mem_data_i[31:0]`.

Top module: `fpld_formatter`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `out_valid_o` is 0 and `out_data_o` is all zeros.
- R2: `out_valid_o` equals `in_valid_i` delayed by one clock. `out_data_o` changes only on an edge where `in_valid_i` is 1, and otherwise keeps its value.
- R3: With `fmt_i` = 2'b01 (double), the result equals the 64-bit `mem_data_i` unchanged.
- R4: With `fmt_i` = 2'b10 (integer word, signed), the result is `mem_data_i[31:0]` in bits [31:0`]`, and every bit of [63:32] is a copy of `mem_data_i[31]`.
- R5: With `fmt_i` = 2'b11 (integer word, unsigned), the result is `mem_data_i[31:0]` in bits [31:0], and bits [63:32] are zero.
- R6: With `fmt_i` = 2'b00 (single), a normal input is widened as follows: the sign is kept, the 8-bit exponent plus 896 becomes the 11-bit exponent, and the 23-bit fraction is placed at the top of the 52-bit fraction with 29 zero bits below it.
- R7: A single zero (exponent 0, fraction 0) becomes a double zero of the same sign.
- R8: A single infinity (exponent 255, fraction 0) becomes a double infinity of the same sign: exponent 0x7FF, fraction 0.
- R9: A single NaN (exponent 255, fraction nonzero) becomes a double NaN: same sign, exponent 0x7FF, and the 23 fraction bits in the top of the double fraction. The quiet bit therefore stays as it was.
- R10: A single denormal (exponent 0, fraction nonzero) is normalized. The fraction is shifted left by k places, where k is one more than its number of leading zeros within 23 bits. The double exponent is 897 − k, and the remaining fraction bits are left-justified.
- R11: For formats 2'b00, 2'b10 and 2'b11, `mem_data_i[63:32]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Memory data and format are valid this cycle |
| fmt_i | input | 2 | Format: 00 single widen, 01 double, 10 word sign-extend, 11 word zero-extend |
| mem_data_i | input | 64 | Raw load data; 32-bit accesses use bits [31:0] |
| out_valid_o | output | 1 | Result is valid |
| out_data_o | output | 64 | Formatted 64-bit register value |

## Verification
Every result appears exactly one clock after the edge that captured a valid input. The bench drives inputs on the falling edge and reads the outputs shortly after the next rising edge, so each check sees the value of that single register stage. To test the hold behaviour, the bench drops `in_valid_i`, changes the data, waits one more edge and confirms that the output has not moved. Expected results come from a bench model that normalizes denormals by shifting one place at a time, not by counting leading zeros.

// File: rtl/fpld_pkg.sv
package fpld_pkg;

  // Register and memory widths
  parameter int unsigned DW      = 64;
  parameter int unsigned WW      = 32;

  // Single-precision field widths
  parameter int unsigned S_EXP_W = 8;
  parameter int unsigned S_FRC_W = 23;

  // Double-precision field widths
  parameter int unsigned D_EXP_W = 11;
  parameter int unsigned D_FRC_W = 52;

  // Derived constants
  localparam int unsigned PAD_W    = D_FRC_W - S_FRC_W;
  localparam int unsigned BIAS_ADJ = (1 << (D_EXP_W - 1)) - (1 << (S_EXP_W - 1));
  localparam int unsigned LZ_W     = $clog2(S_FRC_W + 1);

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_WSX = 2'b10,
    FMT_WZX = 2'b11
  } fpld_fmt_e;

  // Number of leading zeros of a single fraction; only meaningful when f != 0.
  function automatic logic [LZ_W-1:0] frac_lz(input logic [S_FRC_W-1:0] f);
    logic [LZ_W-1:0] n;
    n = LZ_W'(S_FRC_W - 1);
    for (int i = 0; i < S_FRC_W; i++) begin
      if (f[i]) n = LZ_W'(S_FRC_W - 1 - i);
    end
    return n;
  endfunction

  // Exponent of a normal single, rebiased for double precision.
  function automatic logic [D_EXP_W-1:0] rebias(input logic [S_EXP_W-1:0] e);
    return D_EXP_W'(e) + D_EXP_W'(BIAS_ADJ);
  endfunction

endpackage

// File: rtl/fpld_sp_widen.sv
module fpld_sp_widen
  import fpld_pkg::*;
(
  input  logic [WW-1:0] word_i,
  output logic [DW-1:0] dbl_o,
  output logic          is_denorm_o,
  output logic          is_special_o
);

  logic               sgn;
  logic [S_EXP_W-1:0] exp_s;
  logic [S_FRC_W-1:0] frc_s;
  logic               exp_zero, exp_ones, frc_zero;
  logic [LZ_W-1:0]    lz;
  logic [S_FRC_W-1:0] norm_frc;
  logic [D_EXP_W-1:0] norm_exp;

  assign sgn   = word_i[WW-1];
  assign exp_s = word_i[WW-2 -: S_EXP_W];
  assign frc_s = word_i[S_FRC_W-1:0];

  assign exp_zero = (exp_s == '0);
  assign exp_ones = (exp_s == '1);
  assign frc_zero = (frc_s == '0);

  assign is_denorm_o  = exp_zero && !frc_zero;
  assign is_special_o = exp_ones;

  // Denormal normalization: shift past the leading one.
  assign lz       = frac_lz(frc_s);
  assign norm_frc = frc_s << (lz + 1'b1);
  assign norm_exp = D_EXP_W'(BIAS_ADJ) - D_EXP_W'(lz);

  always_comb begin
    if (exp_zero && frc_zero) begin
      dbl_o = {sgn, {(DW-1){1'b0}}};
    end else if (exp_ones) begin
      dbl_o = {sgn, {D_EXP_W{1'b1}}, frc_s, {PAD_W{1'b0}}};
    end else if (exp_zero) begin
      dbl_o = {sgn, norm_exp, norm_frc, {PAD_W{1'b0}}};
    end else begin
      dbl_o = {sgn, rebias(exp_s), frc_s, {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fpld_int_place.sv
module fpld_int_place
  import fpld_pkg::*;
(
  input  logic [WW-1:0] word_i,
  input  logic          sext_i,
  output logic [DW-1:0] val_o
);

  logic fill;

  assign fill  = sext_i & word_i[WW-1];
  assign val_o = {{(DW-WW){fill}}, word_i};

endmodule

// File: rtl/fpld_out_stage.sv
module fpld_out_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end

endmodule

// File: rtl/fpld_formatter.sv
module fpld_formatter
  import fpld_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [1:0]    fmt_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);

  fpld_fmt_e     fmt;
  logic [DW-1:0] sgl_val, int_val, nxt_val;
  logic          sgl_denorm, sgl_special;

  assign fmt = fpld_fmt_e'(fmt_i);

  fpld_sp_widen u_widen (
    .word_i      (mem_data_i[WW-1:0]),
    .dbl_o       (sgl_val),
    .is_denorm_o (sgl_denorm),
    .is_special_o(sgl_special)
  );

  fpld_int_place u_place (
    .word_i(mem_data_i[WW-1:0]),
    .sext_i(fmt == FMT_WSX),
    .val_o (int_val)
  );

  always_comb begin
    unique case (fmt)
      FMT_SGL: nxt_val = sgl_val;
      FMT_DBL: nxt_val = mem_data_i;
      default: nxt_val = int_val;
    endcase
  end

  fpld_out_stage #(.W(DW)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (in_valid_i),
    .d_i   (nxt_val),
    .vld_o (out_valid_o),
    .q_o   (out_data_o)
  );

endmodule

// File: rtl/fpld_formatter_chk.sv
module fpld_formatter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [1:0]  fmt_i,
  input logic [63:0] mem_data_i,
  input logic        out_valid_o,
  input logic [63:0] out_data_o,
  input logic        sgl_denorm,
  input logic        sgl_special
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!out_valid_o && out_data_o == 64'd0));

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));

  // R3
  dbl_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 2'b01) |=> out_data_o == $past(mem_data_i));

  // R4
  sext_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 2'b10) |=>
      (out_data_o[31:0] == $past(mem_data_i[31:0]) &&
       out_data_o[63:32] == {32{$past(mem_data_i[31])}}));

  // R5
  zext_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 2'b11) |=>
      out_data_o == {32'd0, $past(mem_data_i[31:0])});

  // R8 R9
  special_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 2'b00 && sgl_special) |=>
      (out_data_o[62:52] == 11'h7FF && out_data_o[51:29] == $past(mem_data_i[22:0])));

  // R10
  denorm_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fmt_i == 2'b00 && sgl_denorm) |=>
      (out_data_o[62:52] <= 11'd896 && out_data_o[62:52] >= 11'd874 &&
       out_data_o[28:0] == 29'd0));

endmodule

bind fpld_formatter fpld_formatter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .fmt_i      (fmt_i),
  .mem_data_i (mem_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .sgl_denorm (sgl_denorm),
  .sgl_special(sgl_special)
);

// File: tb/fpld_formatter_tb.sv
module fpld_formatter_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic [63:0] mem_data_i = 64'd0;
  logic        out_valid_o;
  logic [63:0] out_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  fpld_formatter dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .fmt_i     (fmt_i),
    .mem_data_i(mem_data_i),
    .out_valid_o(out_valid_o),
    .out_data_o(out_data_o)
  );

  // Independent reference model.
  function automatic logic [63:0] model(input logic [1:0] f, input logic [63:0] d);
    logic [31:0] w;
    logic [23:0] m;
    int          ex;
    w = d[31:0];
    case (f)
      2'b01: return d;
      2'b10: return {{32{w[31]}}, w};
      2'b11: return {32'd0, w};
      default: begin
        if (w[30:23] == 8'hFF)
          return {w[31], 11'h7FF, w[22:0], 29'd0};
        if (w[30:23] == 8'h00) begin
          if (w[22:0] == 23'd0) return {w[31], 63'd0};
          m  = {1'b0, w[22:0]};
          ex = 897;
          while (!m[23]) begin
            m  = m << 1;
            ex = ex - 1;
          end
          return {w[31], 11'(ex), m[22:0], 29'd0};
        end
        return {w[31], 11'(int'(w[30:23]) + 896), w[22:0], 29'd0};
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one valid input and compare the result one clock later.
  task automatic apply(input string req, input logic [1:0] f, input logic [63:0] d);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    fmt_i      = f;
    mem_data_i = d;
    @(posedge clk_i);
    #1;
    check(req, {63'd0, out_valid_o}, 64'd1);
    check(req, out_data_o, model(f, d));
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid", {63'd0, out_valid_o}, 64'd0);
    check("R1 data", out_data_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    apply("R2", 2'b01, 64'h0123_4567_89AB_CDEF);
    prev = out_data_o;
    fmt_i      = 2'b11;
    mem_data_i = 64'hFFFF_0000_FFFF_0000;
    @(posedge clk_i);
    #1;
    check("R2 valid low", {63'd0, out_valid_o}, 64'd0);
    check("R2 hold", out_data_o, prev);
  endtask

  task automatic t_ints();
    apply("R3", 2'b01, 64'hFFF8_0000_0000_0001);
    apply("R4 neg", 2'b10, 64'h0000_0000_8000_0001);
    apply("R4 pos", 2'b10, 64'hFFFF_FFFF_7FFF_FFFF);
    apply("R5", 2'b11, 64'h1234_5678_FEDC_BA98);
  endtask

  task automatic t_single();
    apply("R6 one", 2'b00, 64'h0000_0000_3F80_0000);
    check("R6 one const", out_data_o, 64'h3FF0_0000_0000_0000);
    apply("R6 neg", 2'b00, 64'h0000_0000_C020_0000);
    apply("R6 max", 2'b00, 64'h0000_0000_7F7F_FFFF);
    apply("R6 minnorm", 2'b00, 64'h0000_0000_0080_0000);
    apply("R7 pos", 2'b00, 64'h0000_0000_0000_0000);
    apply("R7 neg", 2'b00, 64'h0000_0000_8000_0000);
    apply("R8 pos", 2'b00, 64'h0000_0000_7F80_0000);
    apply("R8 neg", 2'b00, 64'h0000_0000_FF80_0000);
    apply("R9 qnan", 2'b00, 64'h0000_0000_7FC0_0001);
    apply("R9 snan", 2'b00, 64'h0000_0000_FF80_0001);
    apply("R10 min", 2'b00, 64'h0000_0000_0000_0001);
    check("R10 min const", out_data_o, 64'h36A0_0000_0000_0000);
    apply("R10 top", 2'b00, 64'h0000_0000_0040_0000);
    apply("R10 mix", 2'b00, 64'h0000_0000_8005_A5A5);
    apply("R10 max", 2'b00, 64'h0000_0000_007F_FFFF);
  endtask

  task automatic t_upper_ignored();
    logic [63:0] a;
    apply("R11 sgl", 2'b00, 64'h0000_0000_4049_0FDB);
    a = out_data_o;
    apply("R11 sgl junk", 2'b00, 64'hDEAD_BEEF_4049_0FDB);
    check("R11 sgl same", out_data_o, a);
    apply("R11 sx", 2'b10, 64'h0000_0000_0000_7FFF);
    a = out_data_o;
    apply("R11 sx junk", 2'b10, 64'hFFFF_FFFF_0000_7FFF);
    check("R11 sx same", out_data_o, a);
    apply("R11 zx junk", 2'b11, 64'hA5A5_A5A5_8000_0000);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_ints();
    t_single();
    t_upper_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule